// File: doc/BRIEF.md
# Single-Bin DFT Correlator

This block measures the response of an excited load at one frequency. It takes a stream of signed 12-bit converter samples and multiplies each accepted sample by a cosine reference and by a negated sine reference. Both references come from a 27-bit phase accumulator that steps by the excitation's phase increment. After a fixed window of 1024 accepted samples, the two sums become one real word and one imaginary word: a single-bin discrete Fourier transform evaluated at exactly the excitation frequency.

A sweep controller pulses the start input once per frequency point. The controller then waits for the one-cycle result strobe and reads a signed 16-bit real word, a signed 16-bit imaginary word and their 33-bit magnitude squared. Logic further downstream turns these into impedance magnitude (the square root of R squared plus I squared) and phase (the arctangent of I over R). Each sum is scaled by an arithmetic shift and clamped to 16 bits. The result registers keep their values until the next window completes.

Top module: `dft_corr`

## Requirements
- R1: After the asynchronous active-low reset, valid_o is 0 and re_o, im_o and mag_o are all 0.
- R2: A start_i pulse arms a capture. The capture accepts exactly 1024 samples: those with sample_valid_i high in the cycles after the start cycle. A sample presented in the start cycle itself is not used. Samples arriving while no capture is armed have no effect.
- R3: The 27-bit phase is zero at capture start and advances by phase_inc_i after each accepted sample. The table index k is the top four phase bits [26:23]. The cosine reference is round(127*cos(2*pi*k/16)) and the sine reference is round(127*sin(2*pi*k/16)).
- R4: sample_i is signed two's complement. The real sum is the sum of sample times cosine reference over the window. The imaginary sum is the sum of sample times the negated sine reference.
- R5: Each sum is arithmetically shifted right by 10 bits (floor) and saturated to the range -32768 to 32767 to form re_o and im_o.
- R6: mag_o is the unsigned value re_o*re_o + im_o*im_o, formed from the saturated words.
- R7: valid_o is high for exactly one cycle. It rises on the clock edge after the edge that accepts the 1024th sample, and re_o, im_o and mag_o change on that same edge.
- R8: re_o, im_o and mag_o hold their values until the next capture completes.
- R9: A start_i pulse during a capture discards the partial sums. The aborted capture produces no valid_o.
- R10: Cycles with sample_valid_i low do not advance the phase or the sample count, whatever sample_i carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture start pulse |
| sample_valid_i | input | 1 | sample_i carries a new sample |
| sample_i | input | 12 | Signed converter sample |
| phase_inc_i | input | 27 | Phase increment per accepted sample |
| valid_o | output | 1 | One-cycle result strobe |
| re_o | output | 16 | Signed real result |
| im_o | output | 16 | Signed imaginary result |
| mag_o | output | 33 | Unsigned magnitude squared |

## Verification
Constant samples at zero increment use only the k=0 references. They isolate the shift and the saturation in both directions while the imaginary result stays zero. Cosine- and sine-shaped tones matched to a one-index-per-sample increment load each channel in turn, which exposes swapped channels or a wrong sine sign. Pseudo-random samples under odd and half-rate increments test phase wrap and table indexing. Gapped valid strobes carrying junk data, a sample in the start cycle, restarts in mid-window and idle traffic after completion separate acceptance, restart and hold behaviour from the arithmetic.

// File: rtl/dft_corr_pkg.sv
package dft_corr_pkg;
  localparam int REF_W    = 8;
  localparam int LUT_BITS = 4;

  typedef logic signed [REF_W-1:0] ref_t;

  // 16-point cosine table, amplitude 127
  function automatic ref_t cos_lut(input logic [LUT_BITS-1:0] k);
    case (k)
      4'd0:    return 8'sd127;
      4'd1:    return 8'sd117;
      4'd2:    return 8'sd90;
      4'd3:    return 8'sd49;
      4'd4:    return 8'sd0;
      4'd5:    return -8'sd49;
      4'd6:    return -8'sd90;
      4'd7:    return -8'sd117;
      4'd8:    return -8'sd127;
      4'd9:    return -8'sd117;
      4'd10:   return -8'sd90;
      4'd11:   return -8'sd49;
      4'd12:   return 8'sd0;
      4'd13:   return 8'sd49;
      4'd14:   return 8'sd90;
      default: return 8'sd117;
    endcase
  endfunction
endpackage

// File: rtl/dft_corr_phase.sv
module dft_corr_phase
  import dft_corr_pkg::*;
#(
  parameter int PHASE_W = 27
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               adv_i,
  input  logic [PHASE_W-1:0] inc_i,
  output ref_t               cos_o,
  output ref_t               nsin_o
);
  logic [PHASE_W-1:0]  phase_q;
  logic [LUT_BITS-1:0] k;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (clr_i)  phase_q <= '0;
    else if (adv_i)  phase_q <= phase_q + inc_i;
  end

  assign k      = phase_q[PHASE_W-1 -: LUT_BITS];
  assign cos_o  = cos_lut(k);
  // -sin(x) = cos(x + quarter turn)
  assign nsin_o = cos_lut(k + LUT_BITS'(4));

  AST_PHASE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> phase_q == '0); // R3
endmodule

// File: rtl/dft_corr_mac.sv
module dft_corr_mac #(
  parameter int SAMPLE_W = 12,
  parameter int REF_W    = 8,
  parameter int ACC_W    = 30,
  parameter int N_SAMP   = 1024
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       en_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [REF_W-1:0]    ref_i,
  output logic signed [ACC_W-1:0]    acc_o
);
  localparam int PROD_W = SAMPLE_W + REF_W;
  localparam logic signed [ACC_W-1:0] ACC_LIM =
    ACC_W'(longint'(N_SAMP) * (longint'(1) << (SAMPLE_W-1)) * ((longint'(1) << (REF_W-1)) - 1));

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc_q;

  assign prod = PROD_W'(sample_i) * PROD_W'(ref_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_q + ACC_W'(prod);
  end

  assign acc_o = acc_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q <= ACC_LIM) && (acc_q >= -ACC_LIM)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(acc_q)); // R2
endmodule

// File: rtl/dft_corr_scale.sv
module dft_corr_scale #(
  parameter int ACC_W = 30,
  parameter int OUT_W = 16,
  parameter int SHIFT = 10
) (
  input  logic signed [ACC_W-1:0]   acc_re_i,
  input  logic signed [ACC_W-1:0]   acc_im_i,
  output logic signed [OUT_W-1:0]   re_o,
  output logic signed [OUT_W-1:0]   im_o,
  output logic        [2*OUT_W:0]   mag_o
);
  localparam int MAG_W = 2*OUT_W + 1;
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((longint'(1) << (OUT_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

  logic signed [ACC_W-1:0]   acc [2];
  logic signed [OUT_W-1:0]   val [2];
  logic signed [2*OUT_W-1:0] sq  [2];

  assign acc[0] = acc_re_i;
  assign acc[1] = acc_im_i;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic signed [ACC_W-1:0] shifted;
    assign shifted = acc[c] >>> SHIFT;
    always_comb begin
      if (shifted > SAT_HI)      val[c] = SAT_HI[OUT_W-1:0];
      else if (shifted < SAT_LO) val[c] = SAT_LO[OUT_W-1:0];
      else                       val[c] = shifted[OUT_W-1:0];
    end
    assign sq[c] = (2*OUT_W)'(val[c]) * (2*OUT_W)'(val[c]);
  end

  assign re_o  = val[0];
  assign im_o  = val[1];
  assign mag_o = MAG_W'($unsigned(sq[0])) + MAG_W'($unsigned(sq[1]));
endmodule

// File: rtl/dft_corr.sv
module dft_corr
  import dft_corr_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int PHASE_W   = 27,
  parameter int N_SAMPLES = 1024,
  parameter int OUT_W     = 16,
  parameter int SHIFT     = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       sample_valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [PHASE_W-1:0]         phase_inc_i,
  output logic                       valid_o,
  output logic signed [OUT_W-1:0]    re_o,
  output logic signed [OUT_W-1:0]    im_o,
  output logic [2*OUT_W:0]           mag_o
);
  localparam int CNT_W = $clog2(N_SAMPLES);
  localparam int ACC_W = SAMPLE_W + REF_W + CNT_W;
  localparam int MAG_W = 2*OUT_W + 1;

  logic             busy_q, fin_q, valid_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept, last;

  ref_t                    refs [2];
  logic signed [ACC_W-1:0] acc  [2];
  logic signed [OUT_W-1:0] re_s, im_s, re_q, im_q;
  logic [MAG_W-1:0]        mag_s, mag_q;

  assign accept = sample_valid_i && busy_q && !start_i;
  assign last   = accept && (cnt_q == CNT_W'(N_SAMPLES-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= last;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (accept) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end

  dft_corr_phase #(.PHASE_W(PHASE_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .adv_i  (accept),
    .inc_i  (phase_inc_i),
    .cos_o  (refs[0]),
    .nsin_o (refs[1])
  );

  for (genvar c = 0; c < 2; c++) begin : g_mac
    dft_corr_mac #(
      .SAMPLE_W (SAMPLE_W),
      .REF_W    (REF_W),
      .ACC_W    (ACC_W),
      .N_SAMP   (N_SAMPLES)
    ) u_mac (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (start_i),
      .en_i     (accept),
      .sample_i (sample_i),
      .ref_i    (refs[c]),
      .acc_o    (acc[c])
    );
  end

  dft_corr_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_scale (
    .acc_re_i (acc[0]),
    .acc_im_i (acc[1]),
    .re_o     (re_s),
    .im_o     (im_s),
    .mag_o    (mag_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      re_q    <= '0;
      im_q    <= '0;
      mag_q   <= '0;
    end else begin
      valid_q <= fin_q;
      if (fin_q) begin
        re_q  <= re_s;
        im_q  <= im_s;
        mag_q <= mag_s;
      end
    end
  end

  assign valid_o = valid_q;
  assign re_o    = re_q;
  assign im_o    = im_q;
  assign mag_o   = mag_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> ($stable(re_q) && $stable(im_q) && $stable(mag_q))); // R8
  AST_ABORT_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !fin_q); // R9
endmodule

// File: tb/dft_corr_bench.sv
module dft_corr_bench;
  localparam int  N    = 1024;
  localparam real PI   = 3.14159265358979;
  localparam longint PMASK = (longint'(1) << 27) - 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic               valid = 1'b0;
  logic signed [11:0] sample = '0;
  logic [26:0]        phase_inc = '0;
  logic               valid_o;
  logic signed [15:0] re_o, im_o;
  logic [32:0]        mag_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dft_corr u_dft_corr (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .start_i        (start),
    .sample_valid_i (valid),
    .sample_i       (sample),
    .phase_inc_i    (phase_inc),
    .valid_o        (valid_o),
    .re_o           (re_o),
    .im_o           (im_o),
    .mag_o          (mag_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint rnd(input real r);
    return (r >= 0.0) ? longint'($rtoi(r + 0.5)) : -longint'($rtoi(-r + 0.5));
  endfunction

  function automatic longint cref(input longint k);
    return rnd(127.0 * $cos(2.0 * PI * real'(k) / 16.0));
  endfunction

  function automatic longint sref(input longint k);
    return rnd(127.0 * $sin(2.0 * PI * real'(k) / 16.0));
  endfunction

  // sample patterns: 0 const, 1 pseudo-random, 2 cosine tone, 3 negated sine tone
  function automatic longint gen(input int mode, input int amp, input int n, input longint k);
    longint v;
    case (mode)
      0: return longint'(amp);
      1: begin
        v = (longint'(n) * 1103515245 + longint'(amp)) >> 7;
        return (v & 4095) - 2048;
      end
      2: return rnd(real'(amp) * $cos(2.0 * PI * real'(k) / 16.0));
      default: return -rnd(real'(amp) * $sin(2.0 * PI * real'(k) / 16.0));
    endcase
  endfunction

  function automatic longint sat16(input longint s);
    longint v;
    v = s >>> 10;
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic calc(input longint inc, input int mode, input int amp,
                      output longint er, output longint ei, output longint em);
    longint ph, sr, si, k, x;
    ph = 0; sr = 0; si = 0;
    for (int n = 0; n < N; n++) begin
      k  = ph >> 23;
      x  = gen(mode, amp, n, k);
      sr = sr + x * cref(k);
      si = si - x * sref(k);
      ph = (ph + inc) & PMASK;
    end
    er = sat16(sr);
    ei = sat16(si);
    em = er * er + ei * ei;
  endtask

  task automatic run(input longint inc, input int mode, input int amp,
                     input bit gap, input bit start_sample, input string tag);
    longint er, ei, em, k, ph;
    bit early;
    early = 1'b0;
    ph = 0;
    calc(inc, mode, amp, er, ei, em);
    @(negedge clk);
    start = 1'b1;
    phase_inc = 27'(inc);
    valid = start_sample;
    sample = start_sample ? 12'sh7ff : 12'sh000;
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      if (valid_o) early = 1'b1;
      start = 1'b0;
      k = ph >> 23;
      valid = 1'b1;
      sample = 12'(gen(mode, amp, n, k));
      ph = (ph + inc) & PMASK;
      if (gap && n != N-1) begin
        @(negedge clk);
        if (valid_o) early = 1'b1;
        valid = 1'b0;
        sample = 12'sh5a5;
      end
    end
    @(negedge clk);
    valid = 1'b0;
    chk({"R7 no strobe before window end ", tag}, longint'(early | valid_o), 0);
    @(negedge clk);
    chk({"R7 strobe ", tag}, longint'(valid_o), 1);
    chk({"R4 R5 real ", tag}, longint'(re_o), er);
    chk({"R4 R5 imag ", tag}, longint'(im_o), ei);
    chk({"R6 mag ", tag}, longint'(mag_o), em);
    @(negedge clk);
    chk({"R7 strobe one cycle ", tag}, longint'(valid_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    longint hr, hi, hm;
    bit seen;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", longint'(valid_o), 0);
    chk("R1 reset real", longint'(re_o), 0);
    chk("R1 reset imag", longint'(im_o), 0);
    chk("R1 reset mag", longint'(mag_o), 0);
    rst_n = 1'b1;

    run(0, 0, -3, 1'b0, 1'b0, "dc small");
    run(0, 0, 1000, 1'b0, 1'b0, "dc pos sat");
    run(0, 0, -2048, 1'b0, 1'b0, "dc neg sat");
    run(longint'(1) << 23, 2, 2000, 1'b0, 1'b0, "cos tone");
    run(longint'(1) << 23, 3, 2000, 1'b0, 1'b0, "sin tone imag sat");
    run(longint'(1) << 23, 2, 37, 1'b0, 1'b0, "cos tone small");
    run(longint'(1) << 26, 1, 77, 1'b0, 1'b0, "half rate random");
    run(3 * (longint'(1) << 21) + 12345, 1, 4242, 1'b0, 1'b0, "R3 odd inc random");
    run(27'h5a3c9f1, 1, 999, 1'b0, 1'b1, "R2 start cycle sample");
    run(27'h1234567, 1, 31337, 1'b1, 1'b0, "R10 gapped valid");

    // R2 R8: idle samples are ignored and results hold
    hr = longint'(re_o); hi = longint'(im_o); hm = longint'(mag_o);
    seen = 1'b0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      valid = 1'b1;
      sample = 12'sh7ff;
      if (valid_o) seen = 1'b1;
    end
    @(negedge clk);
    valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 idle no strobe", longint'(seen | valid_o), 0);
    chk("R8 hold real", longint'(re_o), hr);
    chk("R8 hold imag", longint'(im_o), hi);
    chk("R8 hold mag", longint'(mag_o), hm);

    // R9: restart mid-window discards partial sums
    @(negedge clk);
    start = 1'b1;
    phase_inc = 27'd0;
    seen = 1'b0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      start = 1'b0;
      valid = 1'b1;
      sample = 12'sh7ff;
      if (valid_o) seen = 1'b1;
    end
    chk("R9 aborted window no strobe", longint'(seen), 0);
    run(longint'(1) << 22, 1, 555, 1'b0, 1'b0, "R9 after restart");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule